// File: doc/BRIEF.md
# DMA Status and Interrupt Aggregator

This block keeps the status words of a transmit DMA path and a receive DMA path and combines them into one interrupt line. Each path has an 8-bit count of completed packets that software has not yet acknowledged. It also has a sticky "done" bit and a sticky error bit. The error bit means underrun on the transmit side and overflow on the receive side. The engines report each completion or error with a single-cycle pulse.

Software reaches the block through a simple 32-bit register port with a 2-bit word select. A write with bit 0 set to a status word acknowledges one packet: the count goes down by one, and the done bit drops only once the count reaches zero. A write with an error bit set clears that error bit. An 8-bit mask chooses which status bits may raise the interrupt. A read-only word shows the masked pending bits.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every status word, the mask and the pending word read zero, and `irq` is low.
- R2: Word select 0 is the transmit status. It holds the packet count in bits 23:16, underrun in bit 1 and packet-sent in bit 0, and reads zero in all other bits.
- R3: Word select 1 is the receive status. It holds the packet count in bits 23:16, overflow in bit 2 and packet-received in bit 0, and reads zero in all other bits.
- R4: Each completion pulse increments that direction's count modulo 256 (255 wraps to 0) and sets its done bit.
- R5: Writing 1 to bit 0 of a status word decrements that count modulo 256. The done bit clears only when the new count is zero.
- R6: If a completion pulse and an acknowledge write arrive in the same cycle, the count is unchanged and the done bit is set.
- R7: Writing 1 to the error bit (transmit bit 1, receive bit 2) clears it. An error pulse in the same cycle wins and the bit stays set. Writing zeros to a status word changes nothing.
- R8: Word select 2 is the mask. Bits 7:0 are written and read back, and upper bits read zero.
- R9: Word select 3 reads mask AND {receive status bits 3:0, transmit status bits 3:0}, with receive in bits 7:4. Writes to it are ignored.
- R10: `irq` is a register. It is high in the cycle after the masked pending value is non-zero, so it follows any status or mask change by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 tx status, 1 rx status, 2 mask, 3 pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| tx_pkt_done | input | 1 | Transmit packet completed pulse |
| tx_underrun | input | 1 | Transmit underrun pulse |
| rx_pkt_done | input | 1 | Receive packet completed pulse |
| rx_overflow | input | 1 | Receive overflow pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupt packet count shows up on the status word read right after the edge that stored it. It shows up again later, when the done bit clears one acknowledge too early or too late. A stuck or misrouted status bit shows up in the same cycle on the pending word, and on `irq` one clock later. The bench therefore reads a status word after every stimulus step. It checks `irq` both just after the status edge and one edge after it, so an interrupt stage that is missing or doubled is caught. The wrap past 255 and an acknowledge at count zero are driven directly. This exposes any counter that saturates or any done bit that is recomputed from the count.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 8;
    localparam int CNT_LSB  = 16;
    localparam int MASK_W   = 8;
    localparam int NIB_W    = MASK_W / 2;
    localparam int SEL_W    = 2;
    localparam int TX_ERR_POS = 1;
    localparam int RX_ERR_POS = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_TX   = 2'd0,
        SEL_RX   = 2'd1,
        SEL_MASK = 2'd2,
        SEL_PEND = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } dir_stat_t;

    function automatic logic [DATA_W-1:0] pack_stat(dir_stat_t s, int err_pos);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_LSB +: CNT_W] = s.cnt;
        w[0]                = s.done;
        w[err_pos]          = s.err;
        return w;
    endfunction

endpackage

// File: rtl/dma_dir_status.sv
module dma_dir_status
    import dma_irq_pkg::*;
#(
    parameter int ERR_POS = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pkt_evt,
    input  logic      err_evt,
    input  logic      ack_done,
    input  logic      ack_err,
    output dir_stat_t st,
    output logic [NIB_W-1:0] nib
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_stat_t st_q;
    dir_stat_t st_d;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_dec = st_q.cnt - ONE;

    always_comb begin
        st_d = st_q;
        unique case ({pkt_evt, ack_done})
            2'b10: begin
                st_d.cnt  = st_q.cnt + ONE;
                st_d.done = 1'b1;
            end
            2'b01: begin
                st_d.cnt = cnt_dec;
                if (cnt_dec == '0) begin
                    st_d.done = 1'b0;
                end
            end
            2'b11: begin
                st_d.done = 1'b1;
            end
            default: ;
        endcase
        if (err_evt) begin
            st_d.err = 1'b1;
        end else if (ack_err) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [DATA_W-1:0] word;
    assign word = pack_stat(st_q, ERR_POS);
    assign st   = st_q;
    assign nib  = word[NIB_W-1:0];

endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
    import dma_irq_pkg::*;
(
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  dir_stat_t         tx_st,
    input  dir_stat_t         rx_st,
    input  logic [MASK_W-1:0] mask_q,
    input  logic [MASK_W-1:0] pend,
    output logic              tx_ack_done,
    output logic              tx_ack_err,
    output logic              rx_ack_done,
    output logic              rx_ack_err,
    output logic              mask_we,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    logic wr_tx, wr_rx;
    assign wr_tx = reg_wr && (sel == SEL_TX);
    assign wr_rx = reg_wr && (sel == SEL_RX);

    assign tx_ack_done = wr_tx && reg_wdata[0];
    assign tx_ack_err  = wr_tx && reg_wdata[TX_ERR_POS];
    assign rx_ack_done = wr_rx && reg_wdata[0];
    assign rx_ack_err  = wr_rx && reg_wdata[RX_ERR_POS];
    assign mask_we     = reg_wr && (sel == SEL_MASK);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_TX:   reg_rdata = pack_stat(tx_st, TX_ERR_POS);
            SEL_RX:   reg_rdata = pack_stat(rx_st, RX_ERR_POS);
            SEL_MASK: reg_rdata[MASK_W-1:0] = mask_q;
            SEL_PEND: reg_rdata[MASK_W-1:0] = pend;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic [NIB_W-1:0]  tx_nib,
    input  logic [NIB_W-1:0]  rx_nib,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] pend,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign pend = mask_q & {rx_nib, tx_nib};

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |pend;
        end
    end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_pkt_done,
    input  logic        tx_underrun,
    input  logic        rx_pkt_done,
    input  logic        rx_overflow,
    output logic        irq
);

    dir_stat_t         tx_st, rx_st;
    logic [NIB_W-1:0]  tx_nib, rx_nib;
    logic [MASK_W-1:0] mask_q, pend;
    logic tx_ack_done, tx_ack_err, rx_ack_done, rx_ack_err, mask_we;

    dma_reg_port u_port (
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .tx_st       (tx_st),
        .rx_st       (rx_st),
        .mask_q      (mask_q),
        .pend        (pend),
        .tx_ack_done (tx_ack_done),
        .tx_ack_err  (tx_ack_err),
        .rx_ack_done (rx_ack_done),
        .rx_ack_err  (rx_ack_err),
        .mask_we     (mask_we),
        .reg_rdata   (reg_rdata)
    );

    dma_dir_status #(.ERR_POS(TX_ERR_POS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .pkt_evt  (tx_pkt_done),
        .err_evt  (tx_underrun),
        .ack_done (tx_ack_done),
        .ack_err  (tx_ack_err),
        .st       (tx_st),
        .nib      (tx_nib)
    );

    dma_dir_status #(.ERR_POS(RX_ERR_POS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .pkt_evt  (rx_pkt_done),
        .err_evt  (rx_overflow),
        .ack_done (rx_ack_done),
        .ack_err  (rx_ack_err),
        .st       (rx_st),
        .nib      (rx_nib)
    );

    dma_irq_gen u_irq (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata[MASK_W-1:0]),
        .tx_nib     (tx_nib),
        .rx_nib     (rx_nib),
        .mask_q     (mask_q),
        .pend       (pend),
        .irq        (irq)
    );

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        tx_pkt_done,
    input logic        tx_underrun,
    input logic [7:0]  tx_cnt,
    input logic        tx_done_b,
    input logic        tx_err_b,
    input logic [7:0]  mask_q,
    input logic [7:0]  pend,
    input logic        irq
);

    logic tx_ack;
    assign tx_ack = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];

    a_r4_tx_count_up: assert property (@(posedge clk) disable iff (rst)
        (tx_pkt_done && !tx_ack) |=> (tx_cnt == $past(tx_cnt) + 8'd1) && tx_done_b);

    a_r6_tx_collide_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_pkt_done && tx_ack) |=> (tx_cnt == $past(tx_cnt)) && tx_done_b);

    a_r5_tx_clear_at_zero: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && !tx_pkt_done) |=> (tx_done_b == ($past(tx_done_b) && (tx_cnt != 8'd0))));

    a_r7_underrun_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 2'd0) && reg_wdata[1] && !tx_underrun) |=> !tx_err_b);

    a_r7_underrun_set: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> tx_err_b);

    a_r9_pend_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 2'd3)) |=> $stable(mask_q));

    a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|pend)));

endmodule

bind dma_irq_agg dma_irq_agg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .tx_pkt_done (tx_pkt_done),
    .tx_underrun (tx_underrun),
    .tx_cnt      (tx_st.cnt),
    .tx_done_b   (tx_st.done),
    .tx_err_b    (tx_st.err),
    .mask_q      (mask_q),
    .pend        (pend),
    .irq         (irq)
);

// File: tb/tb_dma_irq_agg.sv
module tb_dma_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pkt_done = 1'b0;
    logic        tx_underrun = 1'b0;
    logic        rx_pkt_done = 1'b0;
    logic        rx_overflow = 1'b0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dma_irq_agg dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .tx_pkt_done (tx_pkt_done),
        .tx_underrun (tx_underrun),
        .rx_pkt_done (rx_pkt_done),
        .rx_overflow (rx_overflow),
        .irq         (irq)
    );

    // ev = {rx_overflow, rx_pkt_done, tx_underrun, tx_pkt_done}
    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  ev;
        logic [1:0]  rd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 32'h0,        4'b0001, 2'd0, 32'h0001_0001, 8'd4}, // R4 R2
        '{1'b0, 2'd0, 32'h0,        4'b0001, 2'd0, 32'h0002_0001, 8'd4}, // R4
        '{1'b1, 2'd0, 32'h1,        4'b0000, 2'd0, 32'h0001_0001, 8'd5}, // R5 not yet zero
        '{1'b1, 2'd0, 32'h1,        4'b0001, 2'd0, 32'h0001_0001, 8'd6}, // R6 collision
        '{1'b1, 2'd0, 32'h1,        4'b0000, 2'd0, 32'h0000_0000, 8'd5}, // R5 clears at zero
        '{1'b0, 2'd0, 32'h0,        4'b0010, 2'd0, 32'h0000_0002, 8'd7}, // R7 underrun set
        '{1'b1, 2'd0, 32'h0,        4'b0000, 2'd0, 32'h0000_0002, 8'd7}, // R7 zero write no effect
        '{1'b1, 2'd0, 32'h2,        4'b0010, 2'd0, 32'h0000_0002, 8'd7}, // R7 event wins
        '{1'b1, 2'd0, 32'h2,        4'b0000, 2'd0, 32'h0000_0000, 8'd7}, // R7 cleared
        '{1'b0, 2'd0, 32'h0,        4'b1100, 2'd1, 32'h0001_0005, 8'd3}, // R3
        '{1'b1, 2'd1, 32'h4,        4'b0000, 2'd1, 32'h0001_0001, 8'd7}, // R7 overflow clear
        '{1'b1, 2'd2, 32'hFFFF_FFFF,4'b0000, 2'd2, 32'h0000_00FF, 8'd8}, // R8
        '{1'b1, 2'd2, 32'h0000_0010,4'b0000, 2'd3, 32'h0000_0010, 8'd9}, // R9 masked view
        '{1'b1, 2'd3, 32'hFFFF_FFFF,4'b0000, 2'd2, 32'h0000_0010, 8'd9}, // R9 write ignored
        '{1'b1, 2'd1, 32'h1,        4'b0000, 2'd1, 32'h0000_0000, 8'd5}  // R5 rx clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                        input logic [3:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        {rx_overflow, rx_pkt_done, tx_underrun, tx_pkt_done} = ev;
        @(posedge clk);
        #2;
        reg_wr = 1'b0;
        {rx_overflow, rx_pkt_done, tx_underrun, tx_pkt_done} = 4'b0;
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek(2'd0, "R1 tx", 32'h0);
        peek(2'd1, "R1 rx", 32'h0);
        peek(2'd2, "R1 mask", 32'h0);
        peek(2'd3, "R1 pend", 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].ev);
            peek(VEC[i].rd, $sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
        end

        // R10 irq latency: mask tx sent, then one packet
        step(1'b1, 2'd2, 32'h1, 4'b0000);
        step(1'b0, 2'd0, 32'h0, 4'b0001);
        check("R10 irq not yet", {31'b0, irq}, 32'h0);
        @(posedge clk); #2;
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        step(1'b1, 2'd0, 32'h1, 4'b0000);
        check("R10 irq still high", {31'b0, irq}, 32'h1);
        @(posedge clk); #2;
        check("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R4 wrap: 256 completions bring count back to 0 with sent set
        @(negedge clk);
        tx_pkt_done = 1'b1;
        repeat (256) @(posedge clk);
        #2;
        tx_pkt_done = 1'b0;
        peek(2'd0, "R4 wrap", 32'h0000_0001);
        // R5 acknowledge at count zero wraps to 255, bit stays
        step(1'b1, 2'd0, 32'h1, 4'b0000);
        peek(2'd0, "R5 underflow wrap", 32'h00FF_0001);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        peek(2'd0, "R1 tx after reset", 32'h0);
        peek(2'd2, "R1 mask after reset", 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule